// File: doc/BRIEF.md
# Depth Test Mask and Masked Pixel Store

This block performs hidden surface removal on packed 64-bit words. A depth compare holds newly computed depth values against the values read from the depth buffer. It records one "closer" flag per lane in an 8-bit pixel mask register.

There are two compare forms. A short compare covers four 16-bit lanes and inserts four flags. A long compare covers two 32-bit lanes and inserts two flags. Before inserting, each compare shifts the existing mask toward bit 0 by its own lane count, so the results of several compares build up in one register.

A masked store takes a 64-bit pixel word and a pixel-size code. It produces per-byte write enables from the low-order mask bits, one bit per pixel, and then shifts the bits it used out of the mask. Pixel size and depth size are chosen independently of each other. Any mix is legal, for example two short compares per 8-bit store, or four long compares per two 16-bit stores. Software can also load the mask directly. Address generation and the memory itself sit outside the block, which only presents data and byte enables.

Top module: `zmask_unit`

## Requirements
- R1: After reset the mask register reads 0, and `wr_valid` and `wr_be` are 0.
- R2: A short compare shifts the mask right by 4. It then sets bit 4+i to 1 when the unsigned `new_z[16i+15:16i]` is strictly less than `old_z[16i+15:16i]`, and clears that bit otherwise (i = 0..3).
- R3: A long compare shifts the mask right by 2. It then sets bit 6+j to 1 when the unsigned `new_z[32j+31:32j]` is strictly less than `old_z[32j+31:32j]`, and clears that bit otherwise (j = 0..1).
- R4: Depth comparison is unsigned, and equal or larger new depths leave the inserted bit at 0.
- R5: A store with `pix_size` 0 (8-bit pixels) drives `wr_be[k] = mask[k]` for k = 0..7 and shifts the mask right by 8.
- R6: A store with `pix_size` 1 (16-bit pixels) drives `wr_be[2k+1:2k] = mask[k]` for k = 0..3 and shifts the mask right by 4.
- R7: A store with `pix_size` 2 (24-bit) or 3 (32-bit) behaves identically. It drives `wr_be[4k+3:4k] = mask[k]` for k = 0..1 and shifts the mask right by 2.
- R8: Store results appear one cycle after `store_valid`: `wr_valid` is 1, `wr_data` equals the pixel word, and `wr_be` is as in R5–R7. In cycles without a store result, `wr_valid` and `wr_be` are 0.
- R9: `load_valid` sets the mask to `load_val` on the next cycle and overrides any compare or store update in the same cycle. A store in that same cycle still uses the old mask for its enables.
- R10: A store and a compare in the same cycle work in a fixed order. The store takes its enables from the mask as it stood, the mask is shifted by the store, and the compare then shifts and inserts into that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Perform a depth compare this cycle |
| cmp_long | input | 1 | 1: two 32-bit lanes, 0: four 16-bit lanes |
| new_z | input | 64 | Newly computed depth values |
| old_z | input | 64 | Depth values read from the buffer |
| store_valid | input | 1 | Perform a masked store this cycle |
| pix_size | input | 2 | 0: 8-bit, 1: 16-bit, 2: 24-bit, 3: 32-bit pixels |
| pix_data | input | 64 | Pixel word to be written |
| load_valid | input | 1 | Load the mask from `load_val` |
| load_val | input | 8 | Mask load value |
| mask | output | 8 | Current pixel mask |
| wr_valid | output | 1 | Registered store result is present |
| wr_be | output | 8 | Byte write enables |
| wr_data | output | 64 | Pixel data for the write |

## Verification
The mask register has three writers: compare, store and load. Compare and store are the two functions that meet in the same cycle. The bench drives `cmp_valid` and `store_valid` together, in directed cases and in long random runs. It then checks that the enables reflect the mask before the store, and that the next mask equals the store shift followed by the compare shift and insert. A behavioural model built from bit loops over lanes and pixels predicts this order every clock. Loads are also mixed into those same cycles to show that load overrides the register while the enables still come from the old value.

// File: rtl/zmask_pkg.sv
package zmask_pkg;
   typedef enum logic [1:0] {
      PIX_8  = 2'd0,
      PIX_16 = 2'd1,
      PIX_24 = 2'd2,
      PIX_32 = 2'd3
   } pix_size_e;

   function automatic int unsigned bytes_per_pixel(pix_size_e sz);
      case (sz)
         PIX_8:   return 1;
         PIX_16:  return 2;
         default: return 4;
      endcase
   endfunction
endpackage

// File: rtl/zmask_cmp.sv
module zmask_cmp #(
   parameter int WORD_W = 64,
   parameter int LANE_W = 16
) (
   input  logic [WORD_W-1:0]        new_z,
   input  logic [WORD_W-1:0]        old_z,
   output logic [WORD_W/LANE_W-1:0] closer
);
   localparam int N_LANES = WORD_W / LANE_W;

   if (WORD_W % LANE_W != 0) begin : g_bad_lane
      $error("zmask_cmp: lane width must divide word width");
   end

   for (genvar i = 0; i < N_LANES; i++) begin : g_lane
      assign closer[i] = new_z[i*LANE_W +: LANE_W] < old_z[i*LANE_W +: LANE_W];
   end
endmodule

// File: rtl/zmask_be.sv
module zmask_be
   import zmask_pkg::*;
#(
   parameter int MASK_W = 8
) (
   input  logic [MASK_W-1:0] mask_in,
   input  pix_size_e         size,
   output logic [MASK_W-1:0] be,
   output logic [MASK_W-1:0] mask_after
);
   localparam int N_P8  = MASK_W;
   localparam int N_P16 = MASK_W / 2;
   localparam int N_P32 = MASK_W / 4;

   if (MASK_W % 4 != 0) begin : g_bad_mask
      $error("zmask_be: mask width must be a multiple of 4");
   end

   logic [MASK_W-1:0] be8, be16, be32;

   for (genvar k = 0; k < N_P8; k++) begin : g_p8
      assign be8[k] = mask_in[k];
   end
   for (genvar k = 0; k < N_P16; k++) begin : g_p16
      assign be16[2*k +: 2] = {2{mask_in[k]}};
   end
   for (genvar k = 0; k < N_P32; k++) begin : g_p32
      assign be32[4*k +: 4] = {4{mask_in[k]}};
   end

   always_comb begin
      case (size)
         PIX_8: begin
            be         = be8;
            mask_after = '0;
         end
         PIX_16: begin
            be         = be16;
            mask_after = mask_in >> N_P16;
         end
         default: begin
            be         = be32;
            mask_after = mask_in >> N_P32;
         end
      endcase
   end
endmodule

// File: rtl/zmask_unit.sv
module zmask_unit
   import zmask_pkg::*;
#(
   parameter int WORD_W    = 64,
   parameter int SHORT_Z_W = 16,
   parameter int LONG_Z_W  = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmp_valid,
   input  logic                cmp_long,
   input  logic [WORD_W-1:0]   new_z,
   input  logic [WORD_W-1:0]   old_z,
   input  logic                store_valid,
   input  logic [1:0]          pix_size,
   input  logic [WORD_W-1:0]   pix_data,
   input  logic                load_valid,
   input  logic [WORD_W/8-1:0] load_val,
   output logic [WORD_W/8-1:0] mask,
   output logic                wr_valid,
   output logic [WORD_W/8-1:0] wr_be,
   output logic [WORD_W-1:0]   wr_data
);
   localparam int MASK_W  = WORD_W / 8;
   localparam int N_SHORT = WORD_W / SHORT_Z_W;
   localparam int N_LONG  = WORD_W / LONG_Z_W;

   if (WORD_W % 32 != 0) begin : g_bad_word
      $error("zmask_unit: word width must be a multiple of 32");
   end
   if (N_SHORT > MASK_W || N_LONG > MASK_W) begin : g_bad_lanes
      $error("zmask_unit: more compare lanes than mask bits");
   end

   logic [N_SHORT-1:0] closer_s;
   logic [N_LONG-1:0]  closer_l;
   logic [MASK_W-1:0]  be_c, mask_st, mask_cmp, mask_nx;

   zmask_cmp #(.WORD_W(WORD_W), .LANE_W(SHORT_Z_W)) u_cmp_short (
      .new_z (new_z),
      .old_z (old_z),
      .closer(closer_s)
   );

   zmask_cmp #(.WORD_W(WORD_W), .LANE_W(LONG_Z_W)) u_cmp_long (
      .new_z (new_z),
      .old_z (old_z),
      .closer(closer_l)
   );

   zmask_be #(.MASK_W(MASK_W)) u_be (
      .mask_in   (mask),
      .size      (pix_size_e'(pix_size)),
      .be        (be_c),
      .mask_after(mask_st)
   );

   always_comb begin
      logic [MASK_W-1:0] base;
      base = store_valid ? mask_st : mask;
      if (!cmp_valid)
         mask_cmp = base;
      else if (cmp_long)
         mask_cmp = {closer_l, base[MASK_W-1:N_LONG]};
      else
         mask_cmp = {closer_s, base[MASK_W-1:N_SHORT]};
      mask_nx = load_valid ? load_val : mask_cmp;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask     <= '0;
         wr_valid <= 1'b0;
         wr_be    <= '0;
         wr_data  <= '0;
      end else begin
         mask     <= mask_nx;
         wr_valid <= store_valid;
         wr_be    <= store_valid ? be_c : '0;
         if (store_valid)
            wr_data <= pix_data;
      end
   end
endmodule

// File: rtl/zmask_unit_chk.sv
module zmask_unit_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        cmp_valid,
   input logic        cmp_long,
   input logic [63:0] new_z,
   input logic [63:0] old_z,
   input logic        store_valid,
   input logic [1:0]  pix_size,
   input logic [63:0] pix_data,
   input logic        load_valid,
   input logic [7:0]  load_val,
   input logic [7:0]  mask,
   input logic        wr_valid,
   input logic [7:0]  wr_be,
   input logic [63:0] wr_data
);
   AST_IDLE_NO_BE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_valid |-> wr_be == 8'h00); // R8

   AST_STORE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      store_valid |=> wr_valid && wr_data == $past(pix_data)); // R8

   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      load_valid |=> mask == $past(load_val)); // R9

   AST_SHORT_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && !cmp_long && !load_valid)
         |=> mask[4] == $past(new_z[15:0] < old_z[15:0])); // R2

   AST_LONG_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && cmp_long && !load_valid && !store_valid)
         |=> mask[5:0] == $past(mask[7:2])); // R3

   AST_BYTE_STORE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (store_valid && pix_size == 2'd0 && !cmp_valid && !load_valid)
         |=> mask == 8'h00); // R5

   AST_WIDE_BE_GROUPS: assert property (@(posedge clk) disable iff (!rst_n)
      (store_valid && pix_size[1])
         |=> (wr_be[3:0] == 4'h0 || wr_be[3:0] == 4'hF) && wr_be[7:4] == {4{wr_be[4]}}); // R7
endmodule

bind zmask_unit zmask_unit_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmp_valid  (cmp_valid),
   .cmp_long   (cmp_long),
   .new_z      (new_z),
   .old_z      (old_z),
   .store_valid(store_valid),
   .pix_size   (pix_size),
   .pix_data   (pix_data),
   .load_valid (load_valid),
   .load_val   (load_val),
   .mask       (mask),
   .wr_valid   (wr_valid),
   .wr_be      (wr_be),
   .wr_data    (wr_data)
);

// File: tb/zmask_unit_tb.sv
module zmask_unit_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmp_valid = 1'b0, cmp_long = 1'b0;
   logic [63:0] new_z = '0, old_z = '0;
   logic        store_valid = 1'b0;
   logic [1:0]  pix_size = '0;
   logic [63:0] pix_data = '0;
   logic        load_valid = 1'b0;
   logic [7:0]  load_val = '0;
   logic [7:0]  mask;
   logic        wr_valid;
   logic [7:0]  wr_be;
   logic [63:0] wr_data;

   int tests = 0, fails = 0;
   bit done = 0;

   logic [7:0]  m_mask = '0;
   logic [63:0] m_data = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   zmask_unit u_dut (
      .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_long(cmp_long),
      .new_z(new_z), .old_z(old_z), .store_valid(store_valid),
      .pix_size(pix_size), .pix_data(pix_data), .load_valid(load_valid),
      .load_val(load_val), .mask(mask), .wr_valid(wr_valid),
      .wr_be(wr_be), .wr_data(wr_data)
   );

   task automatic check(string tag, logic [7:0] em, logic ev, logic [7:0] eb, logic [63:0] ed);
      tests++;
      if (mask !== em || wr_valid !== ev || wr_be !== eb || (ev && wr_data !== ed)) begin
         fails++;
         $display("FAIL %s: mask=%h valid=%b be=%h data=%h expected mask=%h valid=%b be=%h data=%h",
                  tag, mask, wr_valid, wr_be, wr_data, em, ev, eb, ed);
      end
   endtask

   // one clock: drive, predict with the model, sample at the following falling edge
   task automatic step(string tag, bit cv, bit cl, logic [63:0] nz, logic [63:0] oz,
                       bit sv, logic [1:0] ps, logic [63:0] pd, bit lv, logic [7:0] lval);
      logic [7:0] m, be;
      int bpp, npix;
      bit ev;
      cmp_valid = cv; cmp_long = cl; new_z = nz; old_z = oz;
      store_valid = sv; pix_size = ps; pix_data = pd; load_valid = lv; load_val = lval;
      m = m_mask; be = 8'h00;
      bpp = (ps == 0) ? 1 : (ps == 1) ? 2 : 4;
      npix = 8 / bpp;
      if (sv) begin
         for (int k = 0; k < npix; k++)
            for (int b = 0; b < bpp; b++)
               be[k*bpp+b] = m_mask[k];
         m = (npix == 8) ? 8'h00 : (m >> npix);
         m_data = pd;
      end
      if (cv) begin
         if (cl) begin
            m = m >> 2;
            for (int j = 0; j < 2; j++) m[6+j] = nz[32*j +: 32] < oz[32*j +: 32];
         end else begin
            m = m >> 4;
            for (int i = 0; i < 4; i++) m[4+i] = nz[16*i +: 16] < oz[16*i +: 16];
         end
      end
      if (lv) m = lval;
      m_mask = m;
      ev = sv;
      @(posedge clk);
      @(negedge clk);
      check(tag, m_mask, ev, be, m_data);
   endtask

   task automatic idle(string tag);
      step(tag, 0, 0, '0, '0, 0, 0, '0, 0, '0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R1 reset", 8'h00, 1'b0, 8'h00, '0);

      // R9 load, then R5 byte store of all eight pixels
      step("R9 load", 0, 0, '0, '0, 0, 0, '0, 1, 8'hA5);
      step("R5 8-bit store", 0, 0, '0, '0, 1, 0, 64'h1122334455667788, 0, '0);
      idle("R8 idle after store");

      // R6 two 16-bit stores drain a loaded mask
      step("R9 load", 0, 0, '0, '0, 0, 0, '0, 1, 8'h69);
      step("R6 16-bit store 1", 0, 0, '0, '0, 1, 1, 64'hCAFE, 0, '0);
      step("R6 16-bit store 2", 0, 0, '0, '0, 1, 1, 64'hBEEF, 0, '0);

      // R7 24 and 32 codes behave the same
      step("R9 load", 0, 0, '0, '0, 0, 0, '0, 1, 8'hB6);
      step("R7 24-bit store", 0, 0, '0, '0, 1, 2, 64'h1, 0, '0);
      step("R9 load", 0, 0, '0, '0, 0, 0, '0, 1, 8'hB6);
      step("R7 32-bit store", 0, 0, '0, '0, 1, 3, 64'h2, 0, '0);

      // R2 R4 short compares: lanes less, equal, greater, unsigned high bit
      step("R9 clear", 0, 0, '0, '0, 0, 0, '0, 1, 8'h00);
      step("R2 short cmp a", 1, 0, 64'h0001_8000_0005_0003, 64'h0002_7FFF_0005_0004, 0, 0, '0, 0, '0);
      step("R4 short cmp b equal", 1, 0, 64'h1234_1234_FFFF_0000, 64'h1234_1233_0000_0001, 0, 0, '0, 0, '0);
      step("R5 8-bit store after 2 short", 0, 0, '0, '0, 1, 0, 64'hDEAD, 0, '0);

      // R3 four long compares feed two 16-bit stores
      step("R3 long cmp 1", 1, 1, 64'h0000_0001_8000_0000, 64'h0000_0002_7FFF_FFFF, 0, 0, '0, 0, '0);
      step("R3 long cmp 2", 1, 1, 64'h5, 64'h6, 0, 0, '0, 0, '0);
      step("R4 long cmp 3 equal", 1, 1, 64'h7_0000_0007, 64'h7_0000_0008, 0, 0, '0, 0, '0);
      step("R3 long cmp 4", 1, 1, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, '0, 0, '0);
      step("R6 16-bit store after longs", 0, 0, '0, '0, 1, 1, 64'h77, 0, '0);
      step("R6 second 16-bit store", 0, 0, '0, '0, 1, 1, 64'h88, 0, '0);

      // R10 store and compare together, R9 load beside both
      step("R9 load", 0, 0, '0, '0, 0, 0, '0, 1, 8'h3C);
      step("R10 store+short", 1, 0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 64'h99, 0, '0);
      step("R10 store+long", 1, 1, 64'h0, 64'h1_0000_0000, 1, 3, 64'hAA, 0, '0);
      step("R9 load with store+cmp", 1, 0, 64'h0, 64'h1, 1, 0, 64'hBB, 1, 8'h5A);
      idle("R8 idle");

      // random mix of everything
      for (int n = 0; n < 2000; n++) begin
         step("R10 random", 1'($urandom), 1'($urandom),
              {$urandom, $urandom} & {4{16'h00FF | 16'($urandom)}}, {$urandom, $urandom},
              1'($urandom), 2'($urandom), {$urandom, $urandom},
              ($urandom % 8) == 0, 8'($urandom));
      end

      // reset mid-run
      step("R9 load", 0, 0, '0, '0, 1, 0, 64'h1, 1, 8'hFF);
      rst_n = 1'b0;
      @(posedge clk); @(negedge clk);
      rst_n = 1'b1;
      m_mask = '0;
      check("R1 reset again", 8'h00, 1'b0, 8'h00, '0);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule